// File: doc/BRIEF.md
# Multiply-Accumulate Register Port

This block sits on the CPU bus and answers every access in the 4 KiB window whose top address nibble is 0x5. It holds two 8-bit operand registers and an unsigned 8x8 multiplier whose 16-bit product can be read back one byte at a time. It also holds an 8-bit accumulator that adds each value written to it and wraps modulo 256. A scratch test register is the last of the CPU registers, and writing it also empties the accumulator.

A 2-bit configuration-pad value is readable in the top two bits of three fixed addresses. On those reads the lower six bits pass through from the open-bus input. The pad value moves to its next setting each time a soft-reset pulse arrives, so a system can cycle through four board settings without a power cycle. Reads elsewhere in the window return the open-bus value unchanged. The block raises a drive-enable for any read inside its window, and outside the window it stays silent.

Writes are registered on the rising clock edge. Reads are combinational from the registered state.

Top module: `mulacc_port`

## Requirements
- R1: Asserting the power-on reset (rst_n low) clears operand A, operand B, the accumulator, the test register and the pad value to zero.
- R2: A write with address bits [1:0] = 0 loads operand A and with [1:0] = 1 loads operand B. A read in 0x5800-0x5FFF with [1:0] = 0 returns the low byte of A*B and with [1:0] = 1 the high byte. The product is valid on the first read cycle after the operand write.
- R3: A write with address bits [1:0] = 2 adds the data to the accumulator modulo 256. A read in 0x5800-0x5FFF with [1:0] = 2 returns the accumulator.
- R4: A write with address bits [1:0] = 3 loads the test register and clears the accumulator in the same edge. A read in 0x5800-0x5FFF with [1:0] = 3 returns the test register.
- R5: Write decoding uses only address bits [1:0] anywhere in 0x5000-0x5FFF, so every alias inside the window acts the same. Writes outside the window change nothing.
- R6: Reads at 0x5000, 0x5400 and 0x5C00 return the pad value in bits [7:6] and open-bus bits [5:0]. A read at 0x5800 is a product-low read, not a pad read.
- R7: Each clock edge with soft_rst high advances the pad value by one, in the cycle 0, 1, 2, 3, 0. Soft reset leaves the operands, the accumulator and the test register unchanged.
- R8: Any other read inside the window returns bus_float unchanged.
- R9: rdata_oe is high exactly when rd_en is high and the address lies in 0x5000-0x5FFF. With rdata_oe low, rdata equals bus_float.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Soft-reset pulse, sampled on the rising edge |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe |
| bus_float | input | 8 | Open-bus value of the data bus |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
A write takes effect at the rising edge where wr_en is sampled. A soft reset steps the pad value at the edge where soft_rst is seen. Reads are combinational, so a value written at one edge, including a product formed from a new operand, is due on the read in the cycle that follows it. The bench changes inputs only on the falling edge. It samples rdata one nanosecond after it sets up a read, which places each check after the edge that committed the state and before the next one.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_OPA,
        WR_OPB,
        WR_ACC,
        WR_TEST
    } wr_sel_e;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_OPEN,
        RD_PAD,
        RD_PLO,
        RD_PHI,
        RD_ACC,
        RD_TEST
    } rd_sel_e;

endpackage

// File: rtl/mulacc_decode.sv
module mulacc_decode
    import mulacc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int TAG_W      = 4,
    parameter logic [TAG_W-1:0] REGION_TAG = 4'h5,
    parameter int PAD_ZERO_W = 10,
    parameter int WIN_BIT    = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              in_range,
    output wr_sel_e           wr_sel,
    output rd_sel_e           rd_sel
);
    logic low_zero;
    logic pad_hit;

    always_comb begin
        in_range = (addr[ADDR_W-1 -: TAG_W] == REGION_TAG);
        low_zero = (addr[PAD_ZERO_W-1:0] == '0);
        // the 0x?800 alias belongs to the ALU window, not the pad
        pad_hit  = low_zero && (addr[WIN_BIT:PAD_ZERO_W] != 2'b10);

        wr_sel = WR_NONE;
        if (wr_en && in_range) begin
            unique case (addr[1:0])
                2'd0: wr_sel = WR_OPA;
                2'd1: wr_sel = WR_OPB;
                2'd2: wr_sel = WR_ACC;
                default: wr_sel = WR_TEST;
            endcase
        end

        rd_sel = RD_NONE;
        if (rd_en && in_range) begin
            if (pad_hit) begin
                rd_sel = RD_PAD;
            end else if (addr[WIN_BIT]) begin
                unique case (addr[1:0])
                    2'd0: rd_sel = RD_PLO;
                    2'd1: rd_sel = RD_PHI;
                    2'd2: rd_sel = RD_ACC;
                    default: rd_sel = RD_TEST;
                endcase
            end else begin
                rd_sel = RD_OPEN;
            end
        end
    end
endmodule

// File: rtl/mulacc_mult.sv
module mulacc_mult #(
    parameter int DATA_W = 8,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [PROD_W-1:0] product
);
    logic [PROD_W-1:0] part [DATA_W];
    logic [PROD_W-1:0] sum  [DATA_W+1];

    assign sum[0] = '0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_row
        assign part[i]  = op_b[i] ? (PROD_W'(op_a) << i) : '0;
        assign sum[i+1] = sum[i] + part[i];
    end

    assign product = sum[DATA_W];
endmodule

// File: rtl/mulacc_regs.sv
module mulacc_regs
    import mulacc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  wr_sel_e           wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] test,
    output logic [PAD_W-1:0]  pad
);
    typedef struct packed {
        logic [DATA_W-1:0] op_a;
        logic [DATA_W-1:0] op_b;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] test;
        logic [PAD_W-1:0]  pad;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (wr_sel)
            WR_OPA:  state_d.op_a = wdata;
            WR_OPB:  state_d.op_b = wdata;
            WR_ACC:  state_d.acc  = state_q.acc + wdata;
            WR_TEST: begin
                state_d.test = wdata;
                state_d.acc  = '0;
            end
            default: ;
        endcase
        if (soft_rst) begin
            state_d.pad = state_q.pad + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign op_a = state_q.op_a;
    assign op_b = state_q.op_b;
    assign acc  = state_q.acc;
    assign test = state_q.test;
    assign pad  = state_q.pad;

    assert_acc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == WR_ACC) |=> (acc == DATA_W'($past(acc) + $past(wdata))));

    assert_test_clears_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == WR_TEST) |=> (acc == '0) && (test == $past(wdata)));

    assert_pad_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (pad == PAD_W'($past(pad) + 1'b1)));

    assert_pad_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(pad));

    assert_opa_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel != WR_OPA) |=> $stable(op_a));
endmodule

// File: rtl/mulacc_rdmux.sv
module mulacc_rdmux
    import mulacc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAD_W  = 2,
    localparam int PROD_W = 2 * DATA_W
) (
    input  rd_sel_e           rd_sel,
    input  logic [DATA_W-1:0] bus_float,
    input  logic [PROD_W-1:0] product,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] test,
    input  logic [PAD_W-1:0]  pad,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (rd_sel)
            RD_PAD:  rdata = {pad, bus_float[DATA_W-PAD_W-1:0]};
            RD_PLO:  rdata = product[DATA_W-1:0];
            RD_PHI:  rdata = product[PROD_W-1:DATA_W];
            RD_ACC:  rdata = acc;
            RD_TEST: rdata = test;
            default: rdata = bus_float;
        endcase
    end
endmodule

// File: rtl/mulacc_port.sv
module mulacc_port
    import mulacc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAD_W  = 2,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] bus_float,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    logic              in_range;
    wr_sel_e           wr_sel;
    rd_sel_e           rd_sel;
    logic [DATA_W-1:0] op_a, op_b, acc, test;
    logic [PAD_W-1:0]  pad;
    logic [PROD_W-1:0] product;

    mulacc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .in_range (in_range),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel)
    );

    mulacc_regs #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_sel   (wr_sel),
        .wdata    (wdata),
        .op_a     (op_a),
        .op_b     (op_b),
        .acc      (acc),
        .test     (test),
        .pad      (pad)
    );

    mulacc_mult #(.DATA_W(DATA_W)) u_mult (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    mulacc_rdmux #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_rdmux (
        .rd_sel    (rd_sel),
        .bus_float (bus_float),
        .product   (product),
        .acc       (acc),
        .test      (test),
        .pad       (pad),
        .rdata     (rdata)
    );

    assign rdata_oe = rd_en && in_range;

    assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> !rdata_oe);

    assert_open_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_range && !addr[11] && (addr[9:0] != '0)) |-> (rdata == bus_float));

    assert_pad_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_range && (addr[9:0] == '0) && (addr[11:10] != 2'b10))
        |-> (rdata[DATA_W-PAD_W-1:0] == bus_float[DATA_W-PAD_W-1:0]));

    assert_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == bus_float));
endmodule

// File: tb/mulacc_port_tb.sv
module mulacc_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  bus_float = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mulacc_port dut_i (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .addr (addr),
        .wdata (wdata), .wr_en (wr_en), .rd_en (rd_en),
        .bus_float (bus_float), .rdata (rdata), .rdata_oe (rdata_oe)
    );

    // operand pairs {a, b}
    localparam logic [15:0] VEC [16] = '{
        16'h0000, 16'h00FF, 16'hFF00, 16'h0101, 16'hFFFF, 16'h8002, 16'h0280,
        16'h1234, 16'hA5A5, 16'h7F81, 16'h0F10, 16'hC30D, 16'h4040, 16'hFE02,
        16'h3377, 16'h9B01
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] fl, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; bus_float = fl; rd_en = 1'b1;
        #1;
        d = rdata; oe = rdata_oe;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] fl, input logic [7:0] exp);
        logic [7:0] d;
        logic oe;
        rd(a, fl, d, oe);
        check(tag, d, exp);
    endtask

    task automatic soft_pulse();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic power_on();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        power_on();

        // R1 reset state
        rd_chk("R1 prod lo", 16'h5800, 8'hAA, 8'h00);
        rd_chk("R1 prod hi", 16'h5801, 8'hAA, 8'h00);
        rd_chk("R1 acc",     16'h5802, 8'hAA, 8'h00);
        rd_chk("R1 test",    16'h5803, 8'hAA, 8'h00);
        rd_chk("R1 pad",     16'h5000, 8'h00, 8'h00);

        // R2 table of products, product read right after operand write
        for (int i = 0; i < 16; i++) begin
            logic [15:0] p;
            p = 16'(VEC[i][15:8]) * 16'(VEC[i][7:0]);
            wr(16'h5000 + 16'(i * 16'h0104), VEC[i][15:8]);
            wr(16'h5001, VEC[i][7:0]);
            rd_chk("R2 prod lo", 16'h5800 + 16'(i * 16'h0004), 8'h5A, p[7:0]);
            rd_chk("R2 prod hi", 16'h5FF1, 8'h5A, p[15:8]);
        end

        // R3 / R4 ordering of accumulate and clear
        wr(16'h5003, 8'h5A);
        rd_chk("R4 acc cleared", 16'h5802, 8'h00, 8'h00);
        rd_chk("R4 test loaded", 16'h5803, 8'h00, 8'h5A);
        wr(16'h5002, 8'h80);
        wr(16'h5002, 8'h90);
        rd_chk("R3 acc wrap", 16'h5802, 8'h00, 8'h10);
        wr(16'h5003, 8'h33);
        rd_chk("R4 clear after sum", 16'h5802, 8'h00, 8'h00);
        wr(16'h5006, 8'h05);
        rd_chk("R3 add after clear", 16'h5FFE, 8'h00, 8'h05);
        rd_chk("R4 test", 16'h5FFF, 8'h00, 8'h33);

        // R5 aliases and out-of-window writes
        wr(16'h57FC, 8'h0B);
        wr(16'h5A31, 8'h0C);
        rd_chk("R5 alias lo", 16'h5804, 8'h00, 8'h84);
        rd_chk("R5 alias hi", 16'h5805, 8'h00, 8'h00);
        wr(16'h4002, 8'h10);
        wr(16'h6002, 8'h10);
        wr(16'h6003, 8'h77);
        rd_chk("R5 outside acc", 16'h5802, 8'h00, 8'h05);
        rd_chk("R5 outside test", 16'h5803, 8'h00, 8'h33);

        // R6 / R7 pad cycling and merge
        rd_chk("R6 pad0 5000", 16'h5000, 8'hFF, 8'h3F);
        soft_pulse();
        rd_chk("R7 pad1 5400", 16'h5400, 8'h2A, 8'h6A);
        soft_pulse();
        rd_chk("R7 pad2 5C00", 16'h5C00, 8'hC0, 8'h80);
        soft_pulse();
        rd_chk("R7 pad3", 16'h5000, 8'h15, 8'hD5);
        rd_chk("R6 5800 is product", 16'h5800, 8'hFF, 8'h84);
        soft_pulse();
        rd_chk("R7 pad wraps", 16'h5400, 8'h00, 8'h00);
        rd_chk("R7 acc kept", 16'h5802, 8'h00, 8'h05);
        rd_chk("R7 test kept", 16'h5803, 8'h00, 8'h33);

        // R8 other reads in window
        rd_chk("R8 5001", 16'h5001, 8'hC3, 8'hC3);
        rd_chk("R8 57FF", 16'h57FF, 8'h3C, 8'h3C);
        rd_chk("R8 5402", 16'h5402, 8'h99, 8'h99);

        // R9 drive enable
        rd(16'h5123, 8'h11, d, oe);
        check("R9 oe inside", {7'd0, oe}, 8'h01);
        rd(16'h4FFF, 8'h22, d, oe);
        check("R9 oe outside", {7'd0, oe}, 8'h00);
        check("R9 rdata outside", d, 8'h22);
        rd(16'h6000, 8'h44, d, oe);
        check("R9 oe 6000", {7'd0, oe}, 8'h00);

        // R1 power-on in mid-run
        soft_pulse();
        power_on();
        rd_chk("R1 pad cleared", 16'h5C00, 8'h00, 8'h00);
        rd_chk("R1 acc cleared", 16'h5802, 8'h00, 8'h00);
        rd_chk("R1 test cleared", 16'h5803, 8'h00, 8'h00);
        rd_chk("R1 prod cleared", 16'h5801, 8'h00, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule